// File: doc/BRIEF.md
# Lockable Device Configuration Register Group

This block holds a small window of dword-addressed configuration registers for a memory-expansion device. It sits on a configuration bus with a 32-bit data path and one enable per byte lane. The window holds five things: a 16-bit device control field, four sticky status flags, a write-once lock flag, and a 64-bit base address for each of two memory ranges. Each written byte passes through a fixed per-bit write mask, so bits that cannot be written keep their stored value.

Software programs the control field and the range bases, then sets the lock flag. From that point the control field and both bases are frozen until a reset. Status flags are raised by single-cycle pulses from inside the device. Software clears them by writing ones. The flags keep their value across a warm reset and are cleared only by a power-on reset. Both reset inputs assert asynchronously and are released through synchronizers. Read data is combinational from the address.

Top module: `cfg_lock_regs`

## Requirements
- R1: After either reset, the control field, the lock flag and both range bases are zero. After a power-on reset the status flags are also zero.
- R2: Word offset 0, bits 15:0, holds the control field. Byte lane 0 writes through mask 0xFD and byte lane 1 through mask 0x4F. A lane whose enable is low keeps its value.
- R3: Offsets 2 and 4 hold the upper 32 bits of range 0 and range 1 and are fully writable per byte. Offsets 3 and 5 hold the lower 32 bits, and only bits 31:28 of those can be written.
- R4: Offset 1, bit 0, is the lock flag. A write with lane 0 enabled and data bit 0 set sets it. Writing 0 has no effect. Once set, the flag stays set until a warm or power-on reset.
- R5: While the lock flag is set, writes to offsets 0 (control), 2, 3, 4 and 5 change nothing.
- R6: Offset 0, bits 19:16, are the status flags. A write with lane 2 enabled clears every flag whose data bit is 1. This works whether or not the lock is set.
- R7: A `status_set` bit sets its flag at the next edge. If a set and a clear hit the same flag in the same cycle, the set wins.
- R8: A warm reset leaves the status flags unchanged. A power-on reset clears them.
- R9: Reads return the stored bits of the addressed word in the same cycle. All bits not listed above read as zero. Addresses outside BASE_WORD..BASE_WORD+5 read as zero, and writes to them change nothing.
- R10: Resets are released synchronously. State is held at its reset value through the second rising edge after both reset inputs are high. The first write that takes effect is one sampled at the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Warm reset, asynchronous active low |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| cfg_addr | input | ADDR_W | Dword address |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte lane enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data |
| status_set | input | 4 | Per-flag set pulses |
| ctl_o | output | 16 | Control field |
| status_o | output | 4 | Status flags |
| lock_o | output | 1 | Lock flag |
| range0_base_o | output | 64 | Range 0 base address |
| range1_base_o | output | 64 | Range 1 base address |

## Verification
A write, a clear or a set pulse sampled at one rising edge appears on the outputs and on `cfg_rdata` right after that edge. A read shows its value in the same cycle that the address is applied. A reset release takes effect only from the third edge after it. The bench drives inputs just after each falling edge, updates a behavioural model at each rising edge, and compares every output and the read data at the following falling edge. Each result is therefore checked exactly one edge after its cause, counting the synchronizer delay on release.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int DATA_W    = 32;
  localparam int LANES     = DATA_W / 8;
  localparam int NUM_WORDS = 6;
  localparam int IDX_CTL   = 0;
  localparam int IDX_LOCK  = 1;
  localparam int ST_W      = 4;
  localparam int ST_LSB    = 16;

  // per-word write mask; lock word is handled on its own
  function automatic logic [DATA_W-1:0] word_mask(input int w);
    case (w)
      0:       return 32'h0000_4FFD;
      2, 4:    return 32'hFFFF_FFFF;
      3, 5:    return 32'hF000_0000;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/cfg_lock_rst_sync.sv
module cfg_lock_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_lock_word.sv
module cfg_lock_word
  import cfg_lock_pkg::*;
#(
  parameter logic [DATA_W-1:0] WMASK = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    localparam logic [7:0] M = WMASK[8*b +: 8];
    logic [7:0] lane_q, lane_nxt;
    logic       lane_en;

    assign lane_en = wr_ok && be[b];

    always_comb begin
      lane_nxt = (wdata[8*b +: 8] & M) | (lane_q & ~M);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (lane_en) lane_q <= lane_nxt;
    end

    assign q[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/cfg_lock_status.sv
module cfg_lock_status #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] st_nxt;
  logic         st_en;

  assign st_en = (|set) || (|clr);

  always_comb begin
    st_nxt = (q & ~clr) | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (st_en) q <= st_nxt;
  end
endmodule

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfg_lock_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BASE_WORD = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_wr,
  input  logic [LANES-1:0]  cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [ST_W-1:0]   status_set,
  output logic [15:0]       ctl_o,
  output logic [ST_W-1:0]   status_o,
  output logic              lock_o,
  output logic [63:0]       range0_base_o,
  output logic [63:0]       range1_base_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_WORD);

  logic core_rst_n, por_core_n;
  logic warm_raw_n;
  logic [ADDR_W-1:0] off;
  logic hit;
  logic [NUM_WORDS-1:0] wsel;
  logic [DATA_W-1:0] words [NUM_WORDS];
  logic [DATA_W-1:0] ctl_word;
  logic lock_q, lock_en;
  logic [ST_W-1:0] st_clr;

  assign warm_raw_n = rst_n & por_n;

  cfg_lock_rst_sync #(.STAGES(2)) u_warm_sync (
    .clk(clk), .arst_n(warm_raw_n), .srst_n(core_rst_n));
  cfg_lock_rst_sync #(.STAGES(2)) u_por_sync (
    .clk(clk), .arst_n(por_n), .srst_n(por_core_n));

  // address decode
  assign off = cfg_addr - BASE_A;
  assign hit = (cfg_addr >= BASE_A) && (off < ADDR_W'(NUM_WORDS));

  always_comb begin
    for (int w = 0; w < NUM_WORDS; w++) begin
      wsel[w] = cfg_wr && hit && (off == ADDR_W'(w));
    end
  end

  // write-once lock flag
  assign lock_en = wsel[IDX_LOCK] && cfg_be[0] && cfg_wdata[0] && !lock_q;

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  lock_q <= 1'b0;
    else if (lock_en) lock_q <= 1'b1;
  end

  // sticky status flags, cleared only by power-on reset or W1C
  assign st_clr = (wsel[IDX_CTL] && cfg_be[ST_LSB/8]) ? cfg_wdata[ST_LSB +: ST_W] : '0;

  cfg_lock_status #(.N(ST_W)) u_status (
    .clk(clk), .rst_n(por_core_n), .set(status_set), .clr(st_clr), .q(status_o));

  // lock-protected masked words
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    if (w == IDX_LOCK) begin : g_lockw
      assign words[w] = {{(DATA_W-1){1'b0}}, lock_q};
    end else begin : g_reg
      logic [DATA_W-1:0] wq;
      cfg_lock_word #(.WMASK(word_mask(w))) u_word (
        .clk(clk), .rst_n(core_rst_n), .wr_ok(wsel[w] && !lock_q),
        .be(cfg_be), .wdata(cfg_wdata), .q(wq));
      if (w == IDX_CTL) begin : g_ctl
        assign ctl_word = wq;
        assign words[w] = wq | (DATA_W'(status_o) << ST_LSB);
      end else begin : g_plain
        assign words[w] = wq;
      end
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (hit && off == ADDR_W'(w)) cfg_rdata = words[w];
    end
  end

  assign ctl_o         = ctl_word[15:0];
  assign lock_o        = lock_q;
  assign range0_base_o = {words[2], words[3]};
  assign range1_base_o = {words[4], words[5]};
endmodule

// File: rtl/cfg_lock_regs_chk.sv
module cfg_lock_regs_chk #(
  parameter int ADDR_W    = 10,
  parameter int BASE_WORD = 64
) (
  input logic              clk,
  input logic              core_rst_n,
  input logic              por_core_n,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic [3:0]        status_set,
  input logic [3:0]        status_o,
  input logic [15:0]       ctl_o,
  input logic              lock_o,
  input logic [63:0]       range0_base_o,
  input logic [63:0]       range1_base_o
);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_WORD);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_WORD + 6);

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    lock_o |=> lock_o);

  // R5
  ctl_frozen_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    lock_o |=> $stable(ctl_o));

  // R5
  range_frozen_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    lock_o |=> ($stable(range0_base_o) && $stable(range1_base_o)));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!por_core_n)
    (|status_set) |=> ((status_o & $past(status_set)) == $past(status_set)));

  // R9
  outside_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((cfg_addr < LO_A) || (cfg_addr >= HI_A)) |-> (cfg_rdata == 32'h0));
endmodule

bind cfg_lock_regs cfg_lock_regs_chk #(.ADDR_W(ADDR_W), .BASE_WORD(BASE_WORD)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .por_core_n(por_core_n),
  .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata), .status_set(status_set),
  .status_o(status_o), .ctl_o(ctl_o), .lock_o(lock_o),
  .range0_base_o(range0_base_o), .range1_base_o(range1_base_o));

// File: tb/cfg_lock_regs_test.sv
module cfg_lock_regs_test;
  localparam int AW   = 10;
  localparam int BASE = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, por_n, cfg_wr;
  logic [AW-1:0] cfg_addr;
  logic [3:0] cfg_be, status_set;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [15:0] ctl_o;
  logic [3:0] status_o;
  logic lock_o;
  logic [63:0] range0_base_o, range1_base_o;

  cfg_lock_regs #(.ADDR_W(AW), .BASE_WORD(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .por_n(por_n), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .status_set(status_set), .ctl_o(ctl_o), .status_o(status_o), .lock_o(lock_o),
    .range0_base_o(range0_base_o), .range1_base_o(range1_base_o));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference
  logic [15:0] m_ctl = '0;
  logic        m_lock = 1'b0;
  logic [3:0]  m_st = '0;
  logic [31:0] m_rng [4] = '{default: '0};
  int wcnt = 0, pcnt = 0;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] d,
                                        logic [31:0] m, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++)
      if (be[b]) r[8*b +: 8] = (d[8*b +: 8] & m[8*b +: 8]) | (old[8*b +: 8] & ~m[8*b +: 8]);
    return r;
  endfunction

  always @(posedge clk) begin
    int o;
    logic [31:0] t;
    logic [3:0] clr;
    o = int'(cfg_addr) - BASE;
    clr = (cfg_wr && o == 0 && cfg_be[2]) ? cfg_wdata[19:16] : 4'h0;
    if (!por_n) begin pcnt = 0; m_st = '0; end
    else if (pcnt < 2) pcnt++;
    else m_st = (m_st & ~clr) | status_set;
    if (!(rst_n && por_n)) begin
      wcnt = 0; m_ctl = '0; m_lock = 1'b0; m_rng = '{default: '0};
    end else if (wcnt < 2) wcnt++;
    else if (cfg_wr && !m_lock) begin
      if (o == 0) begin
        t = merge({16'h0, m_ctl}, cfg_wdata, 32'h0000_4FFD, cfg_be);
        m_ctl = t[15:0];
      end else if (o == 1) begin
        if (cfg_be[0] && cfg_wdata[0]) m_lock = 1'b1;
      end else if (o == 2 || o == 4) begin
        m_rng[o-2] = merge(m_rng[o-2], cfg_wdata, 32'hFFFF_FFFF, cfg_be);
      end else if (o == 3 || o == 5) begin
        m_rng[o-2] = merge(m_rng[o-2], cfg_wdata, 32'hF000_0000, cfg_be);
      end
    end
  end

  function automatic logic [31:0] m_read(logic [AW-1:0] a);
    int o = int'(a) - BASE;
    case (o)
      0: return {12'h0, m_st, m_ctl};
      1: return {31'h0, m_lock};
      2, 3, 4, 5: return m_rng[o-2];
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (!done) begin
    chk("R2 control field", 64'(ctl_o), 64'(m_ctl));
    chk("R4 lock flag", 64'(lock_o), 64'(m_lock));
    chk("R6 status flags", 64'(status_o), 64'(m_st));
    chk("R3 range0 base", range0_base_o, {m_rng[0], m_rng[1]});
    chk("R3 range1 base", range1_base_o, {m_rng[2], m_rng[3]});
    chk("R9 read data", 64'(cfg_rdata), 64'(m_read(cfg_addr)));
  end

  task automatic drive(bit wr, int off, logic [3:0] be, logic [31:0] d, logic [3:0] set);
    @(negedge clk); #2;
    cfg_wr = wr; cfg_addr = AW'(BASE + off); cfg_be = be; cfg_wdata = d; status_set = set;
  endtask

  task automatic idle();
    drive(0, 0, 4'h0, 32'h0, 4'h0);
  endtask

  task automatic expect_rd(string tag, int off, logic [31:0] exp);
    drive(0, off, 4'h0, 32'h0, 4'h0);
    @(negedge clk); #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; por_n = 0; cfg_wr = 0; cfg_addr = '0; cfg_be = '0; cfg_wdata = '0; status_set = '0;
    repeat (3) @(negedge clk);
    // R10: write issued right at release is dropped
    #2; rst_n = 1; por_n = 1;
    cfg_wr = 1; cfg_addr = AW'(BASE); cfg_be = 4'hF; cfg_wdata = 32'hFFFF_FFFF;
    idle(); idle(); idle();
    expect_rd("R10 write during release dropped", 0, 32'h0);
    // R1
    expect_rd("R1 lock after reset", 1, 32'h0);
    expect_rd("R1 range lo after reset", 3, 32'h0);
    // R2
    drive(1, 0, 4'b0011, 32'h0000_FFFF, 4'h0);
    expect_rd("R2 control mask", 0, 32'h0000_4FFD);
    drive(1, 0, 4'b0001, 32'h0, 4'h0);
    expect_rd("R2 byte enable", 0, 32'h0000_4F00);
    // R3
    drive(1, 2, 4'hF, 32'hDEAD_BEEF, 4'h0);
    drive(1, 3, 4'hF, 32'hFFFF_FFFF, 4'h0);
    drive(1, 5, 4'b0111, 32'hFFFF_FFFF, 4'h0);
    drive(1, 4, 4'b1010, 32'h1234_5678, 4'h0);
    expect_rd("R3 range0 hi", 2, 32'hDEAD_BEEF);
    expect_rd("R3 range0 lo mask", 3, 32'hF000_0000);
    expect_rd("R3 range1 lo lanes", 5, 32'h0);
    expect_rd("R3 range1 hi lanes", 4, 32'h1200_5600);
    // R7, R6
    drive(0, 0, 4'h0, 32'h0, 4'b1010);
    expect_rd("R7 set pulse", 0, 32'h000A_4F00);
    drive(1, 0, 4'b0100, 32'h0002_FFFF, 4'h0);
    expect_rd("R6 W1C clears one flag", 0, 32'h0008_4F00);
    drive(1, 0, 4'b0100, 32'h0008_0000, 4'b1000);
    expect_rd("R7 set wins over clear", 0, 32'h0008_4F00);
    // R4 write of zero
    drive(1, 1, 4'hF, 32'hFFFF_FFFE, 4'h0);
    expect_rd("R4 zero write no effect", 1, 32'h0);
    // R8 warm reset keeps status
    @(negedge clk); #2; rst_n = 0;
    idle(); #0; rst_n = 1;
    idle(); idle(); idle();
    expect_rd("R8 status survives warm reset", 0, 32'h0008_0000);
    expect_rd("R1 range after warm reset", 2, 32'h0);
    // R4, R5
    drive(1, 0, 4'h3, 32'h0000_0101, 4'h0);
    drive(1, 2, 4'hF, 32'hCAFE_F00D, 4'h0);
    drive(1, 1, 4'h1, 32'h1, 4'h0);
    expect_rd("R4 lock set", 1, 32'h1);
    drive(1, 0, 4'h3, 32'h0000_FFFF, 4'h0);
    drive(1, 2, 4'hF, 32'h0, 4'h0);
    drive(1, 3, 4'hF, 32'hFFFF_FFFF, 4'h0);
    expect_rd("R5 control frozen", 0, 32'h0008_0101);
    expect_rd("R5 range hi frozen", 2, 32'hCAFE_F00D);
    expect_rd("R5 range lo frozen", 3, 32'h0);
    drive(1, 1, 4'h1, 32'h0, 4'h0);
    expect_rd("R4 lock stays", 1, 32'h1);
    drive(1, 0, 4'h4, 32'h0008_0000, 4'h0);
    expect_rd("R6 W1C while locked", 0, 32'h0000_0101);
    // R9 outside window
    drive(1, -1, 4'hF, 32'hFFFF_FFFF, 4'h0);
    drive(1, 6, 4'hF, 32'hFFFF_FFFF, 4'h0);
    expect_rd("R9 below window", -1, 32'h0);
    expect_rd("R9 above window", 6, 32'h0);
    // R8 cold reset clears status
    drive(0, 0, 4'h0, 32'h0, 4'b0110);
    @(negedge clk); #2; por_n = 0;
    idle(); #0; por_n = 1;
    idle(); idle(); idle();
    expect_rd("R8 cold reset clears status", 0, 32'h0);
    expect_rd("R1 lock cleared", 1, 32'h0);
    // mixed traffic compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom % 100);
      drive(r < 60, int'($urandom % 8) - 1, 4'($urandom), $urandom,
            (r % 7 == 0) ? 4'($urandom) : 4'h0);
      if (i % 500 == 499) begin
        @(negedge clk); #2; rst_n = 0;
        idle(); #0; rst_n = 1;
      end
    end
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule